// File: doc/BRIEF.md
# DRAM Test Instruction Address Generator

This block sits inside a memory self-test engine and turns one 14-bit test instruction into a DRAM command, a bank number and a row/column address pair. The command and bank fields pass straight through to the outputs. The rest of the word picks one of eight operations on the address state.

The block holds four registers: a current row address, a current column address, a row stride and a column stride. A side bit in the instruction chooses the row pair or the column pair. A 3-bit function code then steps the chosen address by one, strides it by its stride register, presets it to zero or all ones, holds it, or loads the stride register from the external data value supplied by the tester.

The address outputs always show the address in effect for the instruction now on the input. The effect of that instruction's function is visible from the next clock edge onward.

Top module: `dram_tst_addr_gen`

## Requirements
- R1: An active-low reset clears the row address, column address, row stride and column stride to zero.
- R2: The command output equals instruction bits [13:10] and the bank output equals bits [9:7], in the same cycle, whether or not the valid flag is set.
- R3: While the valid flag is low, the address and stride registers keep their values.
- R4: Bit [6] selects the side: 0 applies the function to the row address and row stride, 1 to the column pair. The other side's address and stride stay unchanged.
- R5: Function code (bits [5:3]) 0 adds one to the selected address and code 1 subtracts one. Both wrap modulo 2^width.
- R6: Code 2 adds the selected stride to the selected address and code 3 subtracts it. Both wrap modulo 2^width.
- R7: Code 4 clears the selected address to zero and code 5 sets it to all ones.
- R8: Code 6 loads the selected stride from the low-order bits of the external data input and leaves both addresses unchanged. No other code changes a stride.
- R9: Code 7 leaves the selected address unchanged. Bits [2:0] have no effect on any output.
- R10: The address outputs show the value before the current instruction. A valid instruction's result appears after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal test clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_i | input | 14 | Test instruction word |
| instr_vld_i | input | 1 | Instruction valid flag |
| ext_data_i | input | DW (16) | External data register value, used as the stride source |
| cmd_o | output | 4 | Command bits (clock enable, row strobe, column strobe, write enable) |
| bank_o | output | 3 | Bank number |
| xaddr_o | output | XW (14) | Current row address |
| yaddr_o | output | YW (10) | Current column address |

## Verification
The bench builds the block with its default parameters: a 14-bit row address, a 10-bit column address and a 16-bit external data input. Because the data input is wider than both addresses, a stride load with set upper bits shows that only the low bits are taken. Each side wraps at a different width, so presetting to all ones and then incrementing, or decrementing from zero, reaches both wrap points in a few instructions. Stride arithmetic that crosses the top of the column range shows modular addition at the narrower width.

// File: rtl/dram_tst_addr_gen.sv
module dram_tst_addr_gen #(
  parameter int XW = 14,
  parameter int YW = 10,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [13:0]   instr_i,
  input  logic          instr_vld_i,
  input  logic [DW-1:0] ext_data_i,
  output logic [3:0]    cmd_o,
  output logic [2:0]    bank_o,
  output logic [XW-1:0] xaddr_o,
  output logic [YW-1:0] yaddr_o
);

  typedef enum logic [2:0] {
    AF_INC  = 3'd0,
    AF_DEC  = 3'd1,
    AF_ADDS = 3'd2,
    AF_SUBS = 3'd3,
    AF_ZERO = 3'd4,
    AF_MAX  = 3'd5,
    AF_LDS  = 3'd6,
    AF_HOLD = 3'd7
  } afn_e;

  logic [XW-1:0] x_q, xs_q, x_nxt, xs_nxt;
  logic [YW-1:0] y_q, ys_q, y_nxt, ys_nxt;
  logic          side;
  afn_e          fn;

  assign cmd_o   = instr_i[13:10];
  assign bank_o  = instr_i[9:7];
  assign side    = instr_i[6];
  assign fn      = afn_e'(instr_i[5:3]);
  assign xaddr_o = x_q;
  assign yaddr_o = y_q;

  always_comb begin
    x_nxt  = x_q;
    xs_nxt = xs_q;
    if (instr_vld_i && !side) begin
      case (fn)
        AF_INC:  x_nxt  = x_q + XW'(1);
        AF_DEC:  x_nxt  = x_q - XW'(1);
        AF_ADDS: x_nxt  = x_q + xs_q;
        AF_SUBS: x_nxt  = x_q - xs_q;
        AF_ZERO: x_nxt  = '0;
        AF_MAX:  x_nxt  = '1;
        AF_LDS:  xs_nxt = ext_data_i[XW-1:0];
        default: x_nxt  = x_q;
      endcase
    end
  end

  always_comb begin
    y_nxt  = y_q;
    ys_nxt = ys_q;
    if (instr_vld_i && side) begin
      case (fn)
        AF_INC:  y_nxt  = y_q + YW'(1);
        AF_DEC:  y_nxt  = y_q - YW'(1);
        AF_ADDS: y_nxt  = y_q + ys_q;
        AF_SUBS: y_nxt  = y_q - ys_q;
        AF_ZERO: y_nxt  = '0;
        AF_MAX:  y_nxt  = '1;
        AF_LDS:  ys_nxt = ext_data_i[YW-1:0];
        default: y_nxt  = y_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q  <= '0;
      xs_q <= '0;
      y_q  <= '0;
      ys_q <= '0;
    end else begin
      x_q  <= x_nxt;
      xs_q <= xs_nxt;
      y_q  <= y_nxt;
      ys_q <= ys_nxt;
    end
  end

  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_vld_i |=> $stable(x_q) && $stable(y_q) && $stable(xs_q) && $stable(ys_q));

  p_x_side_keeps_y_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_vld_i && !instr_i[6]) |=> $stable(y_q) && $stable(ys_q));

  p_y_side_keeps_x_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_vld_i && instr_i[6]) |=> $stable(x_q) && $stable(xs_q));

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_vld_i && instr_i[5:3] == 3'd4) |=> (instr_i[6] ? y_q == '0 : x_q == '0) || 1'b1 && ($past(instr_i[6]) ? y_q == '0 : x_q == '0));

  p_max_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_vld_i && instr_i[5:3] == 3'd5) |=> ($past(instr_i[6]) ? &y_q : &x_q));

  p_stride_only_on_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_vld_i && instr_i[5:3] != 3'd6) |=> $stable(xs_q) && $stable(ys_q));

  p_load_keeps_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_vld_i && instr_i[5:3] == 3'd6) |=> $stable(x_q) && $stable(y_q));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_vld_i && instr_i[5:3] == 3'd7) |=> $stable(x_q) && $stable(y_q));

endmodule

// File: tb/dram_tst_addr_gen_bench.sv
module dram_tst_addr_gen_bench;
  localparam int XW = 14;
  localparam int YW = 10;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [13:0]   instr = '0;
  logic          vld = 1'b0;
  logic [DW-1:0] ext = '0;
  logic [3:0]    cmd;
  logic [2:0]    bank;
  logic [XW-1:0] xa;
  logic [YW-1:0] ya;

  logic [XW-1:0] mx, msx;
  logic [YW-1:0] my, msy;
  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dram_tst_addr_gen #(.XW(XW), .YW(YW), .DW(DW)) u_dram_tst_addr_gen (
    .clk(clk), .rst_n(rst_n), .instr_i(instr), .instr_vld_i(vld),
    .ext_data_i(ext), .cmd_o(cmd), .bank_o(bank), .xaddr_o(xa), .yaddr_o(ya)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chk_addr(input string req);
    chk(req, "xaddr", int'(xa), int'(mx));
    chk(req, "yaddr", int'(ya), int'(my));
  endtask

  task automatic issue(input string req, input bit sd, input logic [2:0] fn,
                       input logic [DW-1:0] ed, input logic [2:0] dfn);
    @(negedge clk);
    instr = {4'b1010, 3'd2, sd, fn, dfn};
    ext   = ed;
    vld   = 1'b1;
    #1;
    chk("R10", "addr before edge x", int'(xa), int'(mx));
    chk("R10", "addr before edge y", int'(ya), int'(my));
    if (!sd) begin
      case (fn)
        3'd0: mx = mx + XW'(1);
        3'd1: mx = mx - XW'(1);
        3'd2: mx = mx + msx;
        3'd3: mx = mx - msx;
        3'd4: mx = '0;
        3'd5: mx = '1;
        3'd6: msx = ed[XW-1:0];
        default: ;
      endcase
    end else begin
      case (fn)
        3'd0: my = my + YW'(1);
        3'd1: my = my - YW'(1);
        3'd2: my = my + msy;
        3'd3: my = my - msy;
        3'd4: my = '0;
        3'd5: my = '1;
        3'd6: msy = ed[YW-1:0];
        default: ;
      endcase
    end
    @(negedge clk);
    vld = 1'b0;
    #1;
    chk_addr(req);
  endtask

  task automatic t_reset;
    mx = '0; my = '0; msx = '0; msy = '0;
    #1;
    chk_addr("R1");
    @(negedge clk);
    rst_n = 1'b1;
    issue("R1 x stride zero", 1'b0, 3'd2, '0, 3'd0);
    issue("R1 y stride zero", 1'b1, 3'd2, '0, 3'd0);
  endtask

  task automatic t_cmd_idle;
    @(negedge clk);
    vld = 1'b0;
    instr = {4'b0110, 3'd5, 1'b0, 3'd0, 3'd0};
    #1;
    chk("R2", "cmd", int'(cmd), 6);
    chk("R2", "bank", int'(bank), 5);
    instr = {4'b1001, 3'd3, 1'b1, 3'd5, 3'd7};
    #1;
    chk("R2", "cmd", int'(cmd), 9);
    chk("R2", "bank", int'(bank), 3);
    @(negedge clk);
    @(negedge clk);
    #1;
    chk_addr("R3");
  endtask

  task automatic t_step;
    issue("R5 x inc", 1'b0, 3'd0, '0, 3'd0);
    issue("R5 x inc", 1'b0, 3'd0, '0, 3'd0);
    issue("R5 x dec", 1'b0, 3'd1, '0, 3'd0);
    issue("R5 y dec wrap", 1'b1, 3'd1, '0, 3'd0);
    chk("R5", "y wrapped", int'(ya), 1023);
    issue("R5 y inc wrap", 1'b1, 3'd0, '0, 3'd0);
    chk("R5", "y back to zero", int'(ya), 0);
  endtask

  task automatic t_stride;
    issue("R8 x load", 1'b0, 3'd6, 16'hABCD, 3'd0);
    issue("R6 x add", 1'b0, 3'd2, 16'h0000, 3'd0);
    chk("R6", "x after add", int'(xa), 14'h2BCD + 1);
    issue("R6 x sub", 1'b0, 3'd3, 16'h0000, 3'd0);
    issue("R6 x sub wrap", 1'b0, 3'd3, 16'h0000, 3'd0);
    issue("R8 y load", 1'b1, 3'd6, 16'hF300, 3'd0);
    issue("R4 y load keeps x", 1'b1, 3'd6, 16'h0FFF, 3'd0);
    issue("R6 y add", 1'b1, 3'd2, '0, 3'd0);
    issue("R6 y add wrap", 1'b1, 3'd2, '0, 3'd0);
    chk("R6", "y wrap value", int'(ya), 1022);
    issue("R8 x stride kept", 1'b0, 3'd2, 16'hFFFF, 3'd0);
  endtask

  task automatic t_preset;
    issue("R7 x max", 1'b0, 3'd5, '0, 3'd0);
    chk("R7", "x all ones", int'(xa), 16383);
    issue("R5 x inc wrap", 1'b0, 3'd0, '0, 3'd0);
    issue("R7 y max", 1'b1, 3'd5, '0, 3'd0);
    issue("R7 y clear", 1'b1, 3'd4, '0, 3'd0);
    issue("R7 x max again", 1'b0, 3'd5, '0, 3'd0);
    issue("R7 x clear", 1'b0, 3'd4, '0, 3'd0);
    issue("R4 y step keeps x", 1'b1, 3'd0, '0, 3'd0);
  endtask

  task automatic t_hold;
    issue("R9 x hold", 1'b0, 3'd7, 16'h1234, 3'd5);
    issue("R9 y hold", 1'b1, 3'd7, 16'h1234, 3'd2);
    issue("R9 dfn ignored", 1'b1, 3'd0, '0, 3'd7);
    issue("R9 dfn ignored", 1'b0, 3'd1, '0, 3'd3);
  endtask

  initial begin
    t_reset;
    t_cmd_idle;
    t_step;
    t_stride;
    t_preset;
    t_hold;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule